// File: doc/BRIEF.md
# CAN Controller Configuration Guard

This block is the control-register logic at the front of a CAN controller. It holds five mode bits: a halt bit that keeps the controller out of bus activity, an unlock bit that opens the configuration registers, a silent-listening bit, a one-shot (no automatic retransmission) bit and a diagnostic bit. It decides on every host write which of those bits may actually change. The decision always uses the state the register had before the write.

Raising the unlock bit produces two things in the following cycle. The first is a single-cycle clear pulse to the eight status registers of the controller. The second is a preload pulse that loads the timeout counter from a host-programmable period register. While unlock is high, the block holds the transmit and receive handlers in their idle state. It also withdraws permission to write the transmit-buffer add and cancel request registers.

The block sits on a plain register bus with address, write data, write strobe and combinational read data. Address 0 is the control register. Address 1 is the timeout period register. Any other address reads as zero.

Top module: `can_cfg_guard`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x01, with halt=1 and every other bit 0. The period register reads all ones. No clear or preload strobe is active, hold-idle is low, and both write qualifiers are high.
- R2: A write to the unlock bit (bit 1) changes it only if halt was 1 before the write. Otherwise unlock keeps its value.
- R3: A write that takes halt (bit 0) from 1 to 0 leaves unlock at 0 after that write, whatever value was written to bit 1.
- R4: When unlock goes from 0 to 1, all eight clear strobes are high for exactly one cycle, in the cycle after the write. Writing 1 to an unlock that is already 1 gives no strobe. Strobe index order: 0 high-priority status, 1 receive queue 0 status, 2 receive queue 1 status, 3 transmit queue status, 4 pending requests, 5 transmissions done, 6 cancellations done, 7 transmit event queue status.
- R5: The timeout preload strobe is high in the same cycle as the clear strobes. Its value output carries the current period register.
- R6: Hold-idle is high exactly while unlock is 1.
- R7: The transmit-buffer add and cancel write qualifiers are both high exactly while unlock is 0.
- R8: Silent (bit 2) and diagnostic (bit 4) can be set only if halt and unlock were both 1 before the write. Writing 0 to either clears it in any state.
- R9: One-shot (bit 3) changes, in either direction, only if halt and unlock were both 1 before the write.
- R10: A single write of halt=1 and unlock=1 while halt is 0 sets halt but leaves unlock at 0.
- R11: A read of address 0 returns the held bits, including bits whose write was ignored. A read of address 1 returns the period. A read of any other address returns 0, and a write to such an address changes nothing.
- R12: The period register (address 1, TMO_W bits wide) accepts a write in any state and holds its value when not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| stat_clr | output | 8 | Clear strobes for the eight status registers |
| tmo_load | output | 1 | Timeout counter preload strobe |
| tmo_value | output | TMO_W | Value to preload into the timeout counter |
| hdl_hold_idle | output | 1 | Holds transmit and receive handlers idle |
| txadd_wr_ok | output | 1 | Write permission for the buffer add-request register |
| txcancel_wr_ok | output | 1 | Write permission for the buffer cancel-request register |

## Verification
The bench builds the block with its defaults: ADDR_W=4, DATA_W=32 and TMO_W=16. With these values the all-ones reset period is 0xFFFF, which can be told apart from a programmed value. The 4-bit address also leaves spare addresses for testing the read-as-zero and ignored-write cases. The small control field lets a vector table walk every gating combination of halt and unlock against each guarded bit, and reach both the set and clear paths from each prior state.

// File: rtl/can_cfg_pkg.sv
// can_cfg_pkg: shared types and constants for the configuration guard.
// Assumes: the control field is five bits in the layout of ctrl_t.
package can_cfg_pkg;

    // Number of status registers cleared on entry into configuration.
    localparam int NUM_CLR = 8;

    // Control field width and register addresses.
    localparam int CTRL_W    = 5;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_TMO  = 1;

    // Control register layout, bit 0 at the bottom.
    typedef struct packed {
        logic diag;      // bit 4: diagnostic mode
        logic one_shot;  // bit 3: no automatic retransmission
        logic silent;    // bit 2: listen-only
        logic unlock;    // bit 1: configuration open
        logic halt;      // bit 0: controller halted
    } ctrl_t;

    // Index of each status-clear strobe.
    typedef enum int {
        CLR_HIPRI   = 0,
        CLR_RXQ0    = 1,
        CLR_RXQ1    = 2,
        CLR_TXQ     = 3,
        CLR_TXPEND  = 4,
        CLR_TXDONE  = 5,
        CLR_TXCANC  = 6,
        CLR_TXEVENT = 7
    } clr_idx_e;

endpackage

// File: rtl/can_cfg_regbank.sv
// can_cfg_regbank: holds the five control bits and applies the write rules.
// Assumes: every gate looks at the register value before the current write;
// wr_en is high for at most one cycle per host access.
module can_cfg_regbank
    import can_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  ctrl_t wr_val,
    output ctrl_t ctrl_q
);

    ctrl_t ctrl_d;
    logic  open_cfg;
    logic  halt_drop;

    // Guarded bits are open only with both halt and unlock already set.
    always_comb open_cfg = ctrl_q.halt && ctrl_q.unlock;

    // Next-state rules for each bit, based on the pre-write state.
    always_comb begin
        ctrl_d    = ctrl_q;
        halt_drop = 1'b0;
        if (wr_en) begin
            ctrl_d.halt = wr_val.halt;
            if (ctrl_q.halt) begin
                ctrl_d.unlock = wr_val.unlock;
            end
            if (open_cfg) begin
                ctrl_d.silent   = wr_val.silent;
                ctrl_d.diag     = wr_val.diag;
                ctrl_d.one_shot = wr_val.one_shot;
            end else begin
                if (!wr_val.silent) ctrl_d.silent = 1'b0;
                if (!wr_val.diag)   ctrl_d.diag   = 1'b0;
            end
            halt_drop = ctrl_q.halt && !wr_val.halt;
            if (halt_drop) begin
                ctrl_d.unlock = 1'b0;
            end
        end
    end

    // Register the control bits; reset leaves the controller halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{diag: 1'b0, one_shot: 1'b0, silent: 1'b0,
                        unlock: 1'b0, halt: 1'b1};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // R2: unlock cannot move while halt is low.
    p_unlock_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.halt |=> $stable(ctrl_q.unlock));

    // R3: a falling halt always leaves unlock clear.
    p_halt_fall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q.halt) |-> !ctrl_q.unlock);

    // R8: silent and diagnostic only rise from the open state.
    p_silent_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.silent) |-> $past(ctrl_q.halt && ctrl_q.unlock));
    p_diag_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.diag) |-> $past(ctrl_q.halt && ctrl_q.unlock));

    // R9: one-shot only moves from the open state.
    p_oneshot_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q.one_shot) |-> $past(ctrl_q.halt && ctrl_q.unlock));

endmodule

// File: rtl/can_cfg_edge.sv
// can_cfg_edge: detects unlock rising and fans a one-cycle pulse out to the
// status-clear strobes and the timeout preload strobe.
// Assumes: unlock comes straight from a register.
module can_cfg_edge #(
    parameter int NUM_CLR = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unlock,
    output logic [NUM_CLR-1:0] clr,
    output logic               load
);

    logic unlock_d;
    logic rise;

    // Delay unlock by one cycle for the edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) unlock_d <= 1'b0;
        else        unlock_d <= unlock;
    end

    // The pulse lasts for the single cycle in which the two registers differ.
    always_comb rise = unlock && !unlock_d;

    // One strobe per status register.
    for (genvar i = 0; i < NUM_CLR; i++) begin : g_clr
        assign clr[i] = rise;
    end

    // The preload strobe shares the same pulse.
    always_comb load = rise;

    // R4: a strobe never lasts two cycles.
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R4: the strobe needs unlock high.
    p_strobe_needs_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> unlock);

endmodule

// File: rtl/can_cfg_timeout.sv
// can_cfg_timeout: holds the timeout period and presents it as the preload
// value for the timeout counter.
// Assumes: the period can be written in any controller state.
module can_cfg_timeout #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TMO_W-1:0] wr_val,
    output logic [TMO_W-1:0] period_q
);

    // Store the period; it resets to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)     period_q <= '1;
        else if (wr_en) period_q <= wr_val;
    end

    // R12: without a write the period holds.
    p_period_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(period_q));

endmodule

// File: rtl/can_cfg_guard.sv
// can_cfg_guard: top of the configuration guard. Decodes host writes, holds
// the control bits and the timeout period, and drives the strobes, hold-idle
// and write qualifiers.
// Assumes: DATA_W >= TMO_W >= CTRL_W; reads are combinational.
module can_cfg_guard
    import can_cfg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int TMO_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_wr,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_CLR-1:0] stat_clr,
    output logic               tmo_load,
    output logic [TMO_W-1:0]   tmo_value,
    output logic               hdl_hold_idle,
    output logic               txadd_wr_ok,
    output logic               txcancel_wr_ok
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(ADDR_TMO);

    logic             wr_ctrl;
    logic             wr_tmo;
    ctrl_t            ctrl_q;
    logic [TMO_W-1:0] period_q;
    logic             unused_hi;

    // Decode the write strobe by address.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_tmo  = bus_wr && (bus_addr == A_TMO);
    end

    // Upper write-data bits are not stored anywhere.
    always_comb unused_hi = ^bus_wdata[DATA_W-1:TMO_W];

    can_cfg_regbank u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ctrl),
        .wr_val (ctrl_t'(bus_wdata[CTRL_W-1:0])),
        .ctrl_q (ctrl_q)
    );

    can_cfg_edge #(.NUM_CLR(NUM_CLR)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .unlock (ctrl_q.unlock),
        .clr    (stat_clr),
        .load   (tmo_load)
    );

    can_cfg_timeout #(.TMO_W(TMO_W)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_tmo),
        .wr_val   (bus_wdata[TMO_W-1:0]),
        .period_q (period_q)
    );

    // Handler hold and request-register qualifiers follow unlock.
    always_comb begin
        tmo_value      = period_q;
        hdl_hold_idle  = ctrl_q.unlock;
        txadd_wr_ok    = !ctrl_q.unlock;
        txcancel_wr_ok = !ctrl_q.unlock;
    end

    // Read mux: control field, period, or zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)     bus_rdata[CTRL_W-1:0] = ctrl_q;
        else if (bus_addr == A_TMO) bus_rdata[TMO_W-1:0]  = period_q;
    end

    // R4: entering configuration clears every status register at once.
    p_rise_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdl_hold_idle) |-> (&stat_clr && tmo_load));

    // R5: the preload value is the stored period whenever it loads.
    p_load_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_load |-> (tmo_value == period_q));

endmodule

// File: tb/tb_can_cfg_guard.sv
module tb_can_cfg_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  stat_clr;
    logic        tmo_load;
    logic [15:0] tmo_value;
    logic        hdl_hold_idle;
    logic        txadd_wr_ok;
    logic        txcancel_wr_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    can_cfg_guard dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .stat_clr(stat_clr),
        .tmo_load(tmo_load), .tmo_value(tmo_value), .hdl_hold_idle(hdl_hold_idle),
        .txadd_wr_ok(txadd_wr_ok), .txcancel_wr_ok(txcancel_wr_ok)
    );

    typedef struct packed {
        logic [3:0]  waddr;
        logic [31:0] wdata;
        logic [3:0]  raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Walked from reset; each entry is one write then one read.
    localparam vec_t VECS [12] = '{
        '{4'd0, 32'h1F, 4'd0, 32'h03, 8'd8},   // R8 guarded bits closed, R2 unlock opens
        '{4'd0, 32'h1F, 4'd0, 32'h1F, 8'd8},   // R8 open: all set
        '{4'd0, 32'h0B, 4'd0, 32'h0B, 8'd8},   // R8 clear silent/diag
        '{4'd0, 32'h17, 4'd0, 32'h17, 8'd9},   // R9 one-shot cleared while open
        '{4'd0, 32'h14, 4'd0, 32'h14, 8'd3},   // R3 halt falls, unlock forced 0
        '{4'd0, 32'h1E, 4'd0, 32'h14, 8'd2},   // R2 unlock held, R9 one-shot held
        '{4'd0, 32'h03, 4'd0, 32'h01, 8'd10},  // R10 same write cannot set both
        '{4'd0, 32'h1F, 4'd0, 32'h03, 8'd9},   // R9 one-shot still closed
        '{4'd0, 32'h01, 4'd0, 32'h01, 8'd2},   // R2 unlock cleared while halted
        '{4'd1, 32'h1234, 4'd1, 32'h1234, 8'd12}, // R12 period write
        '{4'd2, 32'hFFFF, 4'd2, 32'h0, 8'd11}, // R11 other address reads zero
        '{4'd3, 32'h0, 4'd0, 32'h01, 8'd11}    // R11 other-address write ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        read_chk("R1 ctrl", 4'd0, 32'h01);
        read_chk("R1 period", 4'd1, 32'hFFFF);
        check("R1 clr", {24'd0, stat_clr}, 32'h0);
        check("R1 load", {31'd0, tmo_load}, 32'h0);
        check("R1 hold", {31'd0, hdl_hold_idle}, 32'h0);
        check("R1 qual", {30'd0, txadd_wr_ok, txcancel_wr_ok}, 32'h3);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            do_write(VECS[i].waddr, VECS[i].wdata);
            bus_addr = VECS[i].raddr;
            #1;
            checks++;
            if (bus_rdata !== VECS[i].exp) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual 0x%0h expected 0x%0h",
                         VECS[i].req, i, bus_rdata, VECS[i].exp);
            end
        end

        // R4 R5 R6 R7 entry strobes with reset period
        do_reset();
        do_write(4'd0, 32'h03);
        check("R4 clr all", {24'd0, stat_clr}, 32'hFF);
        check("R5 load", {31'd0, tmo_load}, 32'h1);
        check("R5 value", {16'd0, tmo_value}, 32'hFFFF);
        check("R6 hold high", {31'd0, hdl_hold_idle}, 32'h1);
        check("R7 qual low", {30'd0, txadd_wr_ok, txcancel_wr_ok}, 32'h0);
        @(negedge clk);
        check("R4 clr one cycle", {24'd0, stat_clr}, 32'h0);
        check("R5 load one cycle", {31'd0, tmo_load}, 32'h0);
        // R4 no strobe when already unlocked
        do_write(4'd0, 32'h03);
        check("R4 no re-strobe", {24'd0, stat_clr, 7'd0, tmo_load}, 32'h0);

        // R3 halt drop with unlock written 1
        do_write(4'd0, 32'h02);
        read_chk("R3 forced clear", 4'd0, 32'h00);
        check("R6 hold low", {31'd0, hdl_hold_idle}, 32'h0);
        check("R7 qual high", {30'd0, txadd_wr_ok, txcancel_wr_ok}, 32'h3);

        // R12 period write while running, R5 preload carries it
        do_write(4'd1, 32'hABCD_00A5);
        read_chk("R12 period", 4'd1, 32'h00A5);
        do_write(4'd0, 32'h01);
        check("R4 no strobe on halt", {24'd0, stat_clr}, 32'h0);
        do_write(4'd0, 32'h03);
        check("R5 load new", {31'd0, tmo_load}, 32'h1);
        check("R5 value new", {16'd0, tmo_value}, 32'h00A5);
        read_chk("R11 ctrl readback", 4'd0, 32'h03);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule